// File: doc/BRIEF.md
# Up/Down Timer Counter Unit

This block is an 8-bit counter that moves by one step on each qualified timer tick. A 3-bit source selector picks where the ticks come from. The source can be one of five divided copies of the system clock or an edge of an external pin. The pin is synchronised, and the selector can also pick a falling or a rising edge. Selector code zero stops the counter. A 3-bit mode input decides the counting sequence and the condition that raises the overflow flag. In normal mode the counter wraps. In phase-correct mode it counts up and then back down. In clear-on-match mode it counts up to a compare value and then returns to zero.

A register-style bus can load the count at any time, whether or not ticks arrive, and a load beats any step in the same cycle. The overflow flag is meant to request an interrupt. Software clears it by writing a one to bit 0 through the flag strobe. Two level outputs show when the count is at zero and when it is at the mode's maximum.

Counting direction is held in a two-state machine. In state `DIR_UP` the counter steps upward and in state `DIR_DOWN` it steps downward. Transition *turn-down* (UP to DOWN) is taken on a tick at 0xFF in phase-correct mode. Transition *turn-up* (DOWN to UP) is taken on a tick at 0x00 in phase-correct mode. Transition *force-up* (DOWN to UP) is taken in any cycle in which the mode is not phase-correct.

Top module: `updown_timer`

## Requirements
- R1: Each tick that is not overridden by a bus load changes the count by exactly one. The direction state decides whether the step goes up or down.
- R2: In normal mode (mode code 0, and also the unused codes 3 to 7) the counter steps up and wraps from 0xFF to 0x00. The tick that wraps it sets the overflow flag.
- R3: `at_bottom` is high exactly when the count is 0x00. `at_top` is high when the count equals `top_val` in mode 2, and when the count equals 0xFF in every other mode.
- R4: With `clk_sel` = 0 the count holds its value. In any cycle without a tick the count also holds.
- R5: When `cnt_wr` is high, the next count is `wr_data`, whatever the tick, mode or selector. That cycle produces no step and no overflow event.
- R6: Selector codes 1, 2, 3, 4 and 5 tick when the number of clocks since reset, taken modulo 1, 8, 64, 256 and 1024 respectively, equals the divisor minus one.
- R7: Selector code 7 counts rising edges of `ext_pin` and code 6 counts falling edges. The pin passes two synchroniser flops. A pin level first captured at clock edge k moves the count at edge k+2, and each edge gives exactly one tick.
- R8: Phase-correct mode (mode code 1) steps up to 0xFF. A tick at 0xFF gives 0xFE and turns the direction down. A tick at 0x00 while counting down gives 0x01 and turns it up. The tick that takes the count from 0x01 to 0x00 while counting down sets the overflow flag.
- R9: Clear-on-match mode (mode code 2) clears the count to 0x00 on a tick at `top_val`. If the count was loaded above `top_val`, it climbs to 0xFF, wraps to 0x00 and sets the overflow flag.
- R10: `flag_wr` high with `wr_data[0]` = 1 clears the overflow flag. If a set event occurs in the same cycle, the flag stays set.
- R11: After reset the count is 0x00, the flag is 0, the direction is up and the divider phase is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source: 0 stop, 1..5 divide by 1/8/64/256/1024, 6 pin falling, 7 pin rising |
| mode | input | 3 | Count sequence: 1 phase-correct, 2 clear-on-match, others normal |
| ext_pin | input | 1 | Asynchronous external count input |
| top_val | input | 8 | Compare value used as the top in mode 2 |
| cnt_wr | input | 1 | Load strobe for the count |
| flag_wr | input | 1 | Write strobe for the flag; bit 0 of data = 1 clears |
| wr_data | input | 8 | Bus write data |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Overflow flag (interrupt request) |
| at_bottom | output | 1 | Count is zero |
| at_top | output | 1 | Count is at the mode's maximum |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as an overflow event. The stimulus reaches it by loading 0xFF with the divide-by-1 source, then raising the clear strobe exactly on the cycle of the wrap tick. The two phase-correct turn points are also hard to hit. They are reached by free running long enough to pass both extremes several times. The bench also loads the count in the middle of a downward run, so the direction state outlives the load. A behavioural model checks every clock, and it covers the long divider periods and the pin latency without any directed timing.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [2:0] {
        SEL_STOP     = 3'd0,
        SEL_DIV1     = 3'd1,
        SEL_DIV8     = 3'd2,
        SEL_DIV64    = 3'd3,
        SEL_DIV256   = 3'd4,
        SEL_DIV1024  = 3'd5,
        SEL_PIN_FALL = 3'd6,
        SEL_PIN_RISE = 3'd7
    } tick_src_e;

    localparam logic [2:0] MODE_WRAP  = 3'd0;
    localparam logic [2:0] MODE_PHASE = 3'd1;
    localparam logic [2:0] MODE_MATCH = 3'd2;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
    import timer_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    localparam int LOG_D8    = 3;
    localparam int LOG_D64   = 6;
    localparam int LOG_D256  = 8;
    localparam int LOG_D1024 = 10;

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    always_comb begin
        unique case (tick_src_e'(sel_i))
            SEL_DIV1:    tick_o = 1'b1;
            SEL_DIV8:    tick_o = &phase_q[LOG_D8-1:0];
            SEL_DIV64:   tick_o = &phase_q[LOG_D64-1:0];
            SEL_DIV256:  tick_o = &phase_q[LOG_D256-1:0];
            SEL_DIV1024: tick_o = &phase_q[LOG_D1024-1:0];
            default:     tick_o = 1'b0;
        endcase
    end

    // R6: the divider phase is free-running and advances by one every clock
    a_r6_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_q == $past(phase_q) + 1'b1);

endmodule

// File: rtl/timer_pin_edge.sv
module timer_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], pin_i};
    end

    always_comb begin
        rise_o = sync_q[1] & ~sync_q[2];
        fall_o = ~sync_q[1] & sync_q[2];
    end

    // R7: a detected edge yields a pulse one cycle wide
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
    import timer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [2:0]       mode_i,
    input  logic [WIDTH-1:0] top_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             ovf_evt_o
);
    localparam logic [WIDTH-1:0] CNT_MAX  = '1;
    localparam logic [WIDTH-1:0] CNT_ZERO = '0;
    localparam logic [WIDTH-1:0] CNT_ONE  = WIDTH'(1);

    dir_state_e       state_q, state_d;
    logic [WIDTH-1:0] cnt_q, cnt_d;
    logic             evt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_UP;
        else        state_q <= state_d;
    end

    // count register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_ZERO;
        else        cnt_q <= cnt_d;
    end

    // next state, next count and overflow event
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        evt     = 1'b0;
        if (mode_i != MODE_PHASE) state_d = DIR_UP;        // force-up
        if (wr_en_i) begin
            cnt_d = wr_data_i;
        end else if (tick_i) begin
            if (mode_i == MODE_PHASE) begin
                unique case (state_q)
                    DIR_UP: begin
                        if (cnt_q == CNT_MAX) begin
                            cnt_d   = CNT_MAX - CNT_ONE;
                            state_d = DIR_DOWN;            // turn-down
                        end else begin
                            cnt_d = cnt_q + CNT_ONE;
                        end
                    end
                    DIR_DOWN: begin
                        if (cnt_q == CNT_ZERO) begin
                            cnt_d   = CNT_ONE;
                            state_d = DIR_UP;              // turn-up
                        end else begin
                            cnt_d = cnt_q - CNT_ONE;
                            evt   = (cnt_q == CNT_ONE);
                        end
                    end
                endcase
            end else if (mode_i == MODE_MATCH && cnt_q == top_i) begin
                cnt_d = CNT_ZERO;
            end else begin
                cnt_d = cnt_q + CNT_ONE;
                evt   = (cnt_q == CNT_MAX);
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign ovf_evt_o = evt;

    // R5: a load always lands, whatever the tick
    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> cnt_q == $past(wr_data_i));
    // R4: no tick and no load means the count holds
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(cnt_q));
    // R8: a downward run in phase-correct mode steps by minus one
    a_r8_phase_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PHASE && state_q == DIR_DOWN && tick_i && !wr_en_i && cnt_q != CNT_ZERO)
        |=> cnt_q == $past(cnt_q) - CNT_ONE);
    // R1: outside phase-correct mode the direction is up after one cycle
    a_r1_dir_up_outside_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_PHASE) |=> state_q == DIR_UP);

endmodule

// File: rtl/updown_timer.sv
module updown_timer
    import timer_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [2:0]       mode,
    input  logic             ext_pin,
    input  logic [WIDTH-1:0] top_val,
    input  logic             cnt_wr,
    input  logic             flag_wr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] cnt_q,
    output logic             ovf_flag,
    output logic             at_bottom,
    output logic             at_top
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic presc_tick, pin_rise, pin_fall, tick;
    logic ovf_evt, flag_clr, flag_q;

    timer_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (clk_sel),
        .tick_o (presc_tick)
    );

    timer_pin_edge u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    always_comb begin
        unique case (tick_src_e'(clk_sel))
            SEL_STOP:     tick = 1'b0;
            SEL_PIN_FALL: tick = pin_fall;
            SEL_PIN_RISE: tick = pin_rise;
            default:      tick = presc_tick;
        endcase
    end

    timer_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .mode_i    (mode),
        .top_i     (top_val),
        .wr_en_i   (cnt_wr),
        .wr_data_i (wr_data),
        .cnt_o     (cnt_q),
        .ovf_evt_o (ovf_evt)
    );

    assign flag_clr = flag_wr & wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (ovf_evt)  flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign ovf_flag  = flag_q;
    assign at_bottom = (cnt_q == '0);
    assign at_top    = (mode == MODE_MATCH) ? (cnt_q == top_val) : (cnt_q == CNT_MAX);

    // R10: a set event beats a clear in the same cycle
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && flag_clr) |=> ovf_flag);
    // R4: a stopped source with no load freezes the count
    a_r4_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));
    // R10: a clear with no event drops the flag
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !ovf_evt) |=> !ovf_flag);

endmodule

// File: tb/test_updown_timer.sv
module test_updown_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic [2:0] mode = 3'd0;
    logic       ext_pin = 1'b0;
    logic [7:0] top_val = 8'h00;
    logic       cnt_wr = 1'b0;
    logic       flag_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cnt_q;
    logic       ovf_flag, at_bottom, at_top;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R11";

    // reference model state
    int m_cnt = 0;
    bit m_down = 1'b0;
    bit m_flag = 1'b0;
    int m_pre = 0;
    bit p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;

    always #5 clk = ~clk;

    updown_timer i_updown_timer (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .mode(mode),
        .ext_pin(ext_pin), .top_val(top_val), .cnt_wr(cnt_wr),
        .flag_wr(flag_wr), .wr_data(wr_data), .cnt_q(cnt_q),
        .ovf_flag(ovf_flag), .at_bottom(at_bottom), .at_top(at_top)
    );

    always @(posedge clk) begin
        bit tk, ev;
        if (!rst_n) begin
            m_cnt = 0; m_down = 0; m_flag = 0; m_pre = 0;
            p1 = 0; p2 = 0; p3 = 0;
        end else begin
            case (clk_sel)
                3'd1: tk = 1;
                3'd2: tk = (m_pre % 8) == 7;
                3'd3: tk = (m_pre % 64) == 63;
                3'd4: tk = (m_pre % 256) == 255;
                3'd5: tk = (m_pre % 1024) == 1023;
                3'd6: tk = !p2 && p3;
                3'd7: tk = p2 && !p3;
                default: tk = 0;
            endcase
            ev = 0;
            if (cnt_wr) begin
                m_cnt = wr_data;
            end else if (tk) begin
                if (mode == 3'd1) begin
                    if (!m_down) begin
                        if (m_cnt == 255) begin m_cnt = 254; m_down = 1; end
                        else m_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin m_cnt = 1; m_down = 0; end
                        else begin ev = (m_cnt == 1); m_cnt = m_cnt - 1; end
                    end
                end else if (mode == 3'd2 && m_cnt == top_val) begin
                    m_cnt = 0;
                end else begin
                    ev = (m_cnt == 255);
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
            if (mode != 3'd1) m_down = 0;
            if (ev) m_flag = 1;
            else if (flag_wr && wr_data[0]) m_flag = 0;
            m_pre = (m_pre + 1) % 1024;
            p3 = p2; p2 = p1; p1 = ext_pin;
        end
    end

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit etop;
        etop = (mode == 3'd2) ? (m_cnt == top_val) : (m_cnt == 255);
        checks++;
        if (cnt_q !== 8'(m_cnt)) begin
            errors++;
            $display("FAIL %s cnt actual %0h expected %0h at %0t", cur_req, cnt_q, m_cnt, $time);
        end
        check_bit("flag", ovf_flag, m_flag);
        check_bit("R3 bottom", at_bottom, m_cnt == 0);
        check_bit("R3 top", at_top, etop);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic load(logic [7:0] v);
        cnt_wr = 1; wr_data = v;
        step();
        cnt_wr = 0;
    endtask

    task automatic clear_flag();
        flag_wr = 1; wr_data = 8'h01;
        step();
        flag_wr = 0;
    endtask

    task automatic pin_run(int edges, int gap);
        for (int e = 0; e < edges; e++) begin
            ext_pin = ~ext_pin;
            run(gap);
        end
    endtask

    initial begin
        // R11: reset state
        cur_req = "R11";
        run(3);
        check_bit("R11 reset count zero", cnt_q == 8'h00, 1'b1);
        check_bit("R11 reset flag", ovf_flag, 1'b0);
        rst_n = 1;
        run(2);

        // R4: stopped source freezes; R5: load while stopped
        cur_req = "R4";
        mode = 3'd0; clk_sel = 3'd0;
        run(20);
        cur_req = "R5";
        load(8'h37);
        cur_req = "R4";
        run(30);
        check_bit("R4 frozen at loaded value", cnt_q == 8'h37, 1'b1);

        // R2 / R1: normal wrap at divide by 1
        cur_req = "R2";
        clk_sel = 3'd1;
        load(8'hF0);
        run(40);
        check_bit("R2 flag after wrap", ovf_flag, 1'b1);

        // R10: plain clear, then collision with a set event
        cur_req = "R10";
        clear_flag();
        check_bit("R10 cleared", ovf_flag, 1'b0);
        load(8'hFF);
        flag_wr = 1; wr_data = 8'h01;
        step();
        flag_wr = 0;
        check_bit("R10 set beats clear", ovf_flag, 1'b1);
        flag_wr = 1; wr_data = 8'h02;   // bit 0 zero: no clear
        step();
        flag_wr = 0;
        check_bit("R10 bit0 zero keeps flag", ovf_flag, 1'b1);
        clear_flag();

        // R5: loads during ticks, including on the wrap tick
        cur_req = "R5";
        for (int k = 0; k < 6; k++) begin
            load(8'(8'hFF - k));
            run(3);
        end
        load(8'h10);
        check_bit("R5 load overrides tick", cnt_q == 8'h10, 1'b1);

        // R6: prescaler taps
        cur_req = "R6";
        clk_sel = 3'd2; run(300);
        clk_sel = 3'd3; run(400);
        clk_sel = 3'd4; run(600);
        clk_sel = 3'd5; run(2100);

        // R8: phase-correct with reversals, load in a downward run
        cur_req = "R8";
        clear_flag();
        mode = 3'd1; clk_sel = 3'd1;
        load(8'hF8);
        run(600);
        load(8'h05);
        run(20);
        check_bit("R8 flag set at bottom", ovf_flag, 1'b1);
        load(8'h00);
        run(5);

        // R9: clear-on-match, then above-top load wrapping
        cur_req = "R9";
        clear_flag();
        mode = 3'd2; top_val = 8'h20;
        load(8'h00);
        run(120);
        check_bit("R9 no flag below top", ovf_flag, 1'b0);
        load(8'h30);
        run(230);
        check_bit("R9 flag after wrap above top", ovf_flag, 1'b1);
        top_val = 8'hFF;
        run(300);

        // R7: external pin edges
        cur_req = "R7";
        mode = 3'd0; clear_flag();
        clk_sel = 3'd7;
        load(8'h00);
        pin_run(20, 3);
        pin_run(10, 1);
        clk_sel = 3'd6;
        pin_run(20, 4);
        pin_run(8, 2);
        check_bit("R7 pin edges counted", cnt_q != 8'h00, 1'b1);

        // R2: unused mode code behaves as normal; R1 step
        cur_req = "R2";
        mode = 3'd5; clk_sel = 3'd1;
        load(8'hFC);
        run(10);
        cur_req = "R1";
        mode = 3'd1;
        run(300);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule